// File: doc/BRIEF.md
# Floating-Point Pipe Issue and Occupancy Controller

This block governs admission into a single five-stage floating-point execution pipe that is not fully pipelined. It offers one instruction slot per cycle on a valid/ready handshake. Each offered instruction carries a tag, a precision flag and a class bit. The block tracks which stages hold work, decides whether the offered instruction may enter, and reports each retirement as a one-cycle output pulse that carries the retiring tag and precision flag. No arithmetic is done: tags simply travel through the stages.

Two classes exist. Pipelined operations, which include fused multiply-add in either precision, flow through the five stages. The unit refuses entry whenever its first four stages are all occupied, so a continuous stream is admitted at four instructions per five cycles. Long operations, such as division or reciprocal estimates, take the whole unit for a latency of 14 to 35 cycles. That latency comes with the instruction. While a long operation runs, nothing else enters.

Top module: `fpu_issue_ctl`

## Requirements
- R1: In the first cycle after synchronous active-high reset is released, out_valid is 0 and in_ready is 1 for an offered pipelined instruction, because all stages and the long-operation counter have been cleared.
- R2: A pipelined instruction (in_cls = 0) accepted in cycle c produces out_valid = 1 in cycle c+5, carrying its tag.
- R3: At most one retirement appears per cycle, and instructions retire in the order they were accepted.
- R4: in_ready is 0 for a pipelined instruction in every cycle in which stages one to four all hold work. When valid is held high continuously from an empty unit, exactly 16 of 20 consecutive cycles accept.
- R5: The precision flag (in_dbl, 1 = double) never changes timing, and it is returned on out_dbl with the retirement.
- R6: A long instruction (in_cls = 1) accepted in cycle c with an effective latency L retires with its tag in cycle c+L.
- R7: The effective latency L is in_lat when in_lat is between 14 and 35. Below 14 it is 14, and above 35 it is 35.
- R8: A long instruction is accepted only when no stage holds work and no long operation is in progress. Otherwise in_ready is 0 for it.
- R9: After a long instruction is accepted, in_ready is 0 for every class from the next cycle through the cycle in which that instruction retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered this cycle |
| in_ready | output | 1 | Offered instruction may enter this cycle |
| in_tag | input | TAG_W | Instruction tag |
| in_dbl | input | 1 | Precision flag, 1 = double |
| in_cls | input | 1 | Class, 0 = pipelined, 1 = long |
| in_lat | input | LAT_W | Requested latency for a long instruction |
| out_valid | output | 1 | One-cycle retirement pulse |
| out_tag | output | TAG_W | Tag of the retiring instruction |
| out_dbl | output | 1 | Precision flag of the retiring instruction |

## Verification
The bench builds the block with its default parameters: five stages, an admission gate over the first four, latency bounds of 14 and 35, a 6-bit latency field and 8-bit tags. Because the 6-bit field spans 0 to 63, random long requests reach both clamp limits and the values between them. The 8-bit tags are distinct across the longest in-flight window, so any retirement out of order shows up as a tag mismatch. Random mixes of the two classes bring in the cases where a long instruction waits for the stages to drain and where a pipelined stream meets the four-of-five gate.

// File: rtl/fpu_ic_pkg.sv
package fpu_ic_pkg;

    typedef enum logic {
        OPC_PIPE = 1'b0,
        OPC_LONG = 1'b1
    } op_class_e;

    localparam int unsigned DEF_NSTAGE  = 5;
    localparam int unsigned DEF_GATE    = 4;
    localparam int unsigned DEF_MIN_LAT = 14;
    localparam int unsigned DEF_MAX_LAT = 35;

    function automatic int unsigned clamp_u(input int unsigned v,
                                            input int unsigned lo,
                                            input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/fpu_ic_stages.sv
module fpu_ic_stages #(
    parameter int unsigned NSTAGE = 5,
    parameter int unsigned TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic              push_dbl,
    output logic [NSTAGE-1:0] occ,
    output logic              ret_valid,
    output logic [TAG_W-1:0]  ret_tag,
    output logic              ret_dbl
);
    typedef struct packed {
        logic             v;
        logic [TAG_W-1:0] tag;
        logic             dbl;
    } slot_t;

    slot_t st [NSTAGE];

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    st[g] <= '0;
                end else begin
                    st[g].v   <= push;
                    st[g].tag <= push_tag;
                    st[g].dbl <= push_dbl;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) st[g] <= '0;
                else     st[g] <= st[g-1];
            end
        end
        assign occ[g] = st[g].v;
    end

    assign ret_valid = st[NSTAGE-1].v;
    assign ret_tag   = st[NSTAGE-1].tag;
    assign ret_dbl   = st[NSTAGE-1].dbl;

endmodule

// File: rtl/fpu_ic_long.sv
module fpu_ic_long
    import fpu_ic_pkg::*;
#(
    parameter int unsigned LAT_W   = 6,
    parameter int unsigned TAG_W   = 8,
    parameter int unsigned MIN_LAT = 14,
    parameter int unsigned MAX_LAT = 35
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LAT_W-1:0] lat,
    input  logic [TAG_W-1:0] tag,
    input  logic             dbl,
    output logic             busy,
    output logic             done,
    output logic [TAG_W-1:0] done_tag,
    output logic             done_dbl
);
    localparam int unsigned CNT_W = $clog2(MAX_LAT + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    assign load_val = CNT_W'(clamp_u(32'(lat), MIN_LAT, MAX_LAT) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            done_tag <= '0;
            done_dbl <= 1'b0;
        end else if (start) begin
            busy     <= 1'b1;
            cnt      <= load_val;
            done_tag <= tag;
            done_dbl <= dbl;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    AST_LONG_LOAD_RANGE: assert property (@(posedge clk) disable iff (rst)
        start |=> busy && (cnt >= CNT_W'(MIN_LAT - 1)) && (cnt <= CNT_W'(MAX_LAT - 1))); // R7

    AST_LONG_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> !busy); // R6

endmodule

// File: rtl/fpu_ic_gate.sv
module fpu_ic_gate
    import fpu_ic_pkg::*;
#(
    parameter int unsigned NSTAGE = 5,
    parameter int unsigned GATE   = 4
) (
    input  logic [NSTAGE-1:0] occ,
    input  logic              busy,
    input  logic              in_valid,
    input  logic              in_cls,
    output logic              in_ready,
    output logic              acc_pipe,
    output logic              acc_long
);
    logic front_full;
    logic all_empty;
    logic pipe_ok;
    logic long_ok;
    op_class_e cls;

    assign cls        = op_class_e'(in_cls);
    assign front_full = &occ[GATE-1:0];
    assign all_empty  = ~|occ;
    assign pipe_ok    = !busy && !front_full;
    assign long_ok    = !busy && all_empty;

    always_comb begin
        in_ready = 1'b0;
        acc_pipe = 1'b0;
        acc_long = 1'b0;
        unique case (cls)
            OPC_PIPE: begin
                in_ready = pipe_ok;
                acc_pipe = in_valid && pipe_ok;
            end
            OPC_LONG: begin
                in_ready = long_ok;
                acc_long = in_valid && long_ok;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fpu_issue_ctl.sv
module fpu_issue_ctl
    import fpu_ic_pkg::*;
#(
    parameter int unsigned NSTAGE  = DEF_NSTAGE,
    parameter int unsigned GATE    = DEF_GATE,
    parameter int unsigned MIN_LAT = DEF_MIN_LAT,
    parameter int unsigned MAX_LAT = DEF_MAX_LAT,
    parameter int unsigned LAT_W   = 6,
    parameter int unsigned TAG_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             in_dbl,
    input  logic             in_cls,
    input  logic [LAT_W-1:0] in_lat,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_dbl
);
    localparam int unsigned SR_W = $clog2(NSTAGE + 1);

    logic [NSTAGE-1:0] occ;
    logic              busy;
    logic              acc_pipe;
    logic              acc_long;
    logic              p_ret_v;
    logic [TAG_W-1:0]  p_ret_tag;
    logic              p_ret_dbl;
    logic              l_done;
    logic [TAG_W-1:0]  l_tag;
    logic              l_dbl;

    fpu_ic_gate #(.NSTAGE(NSTAGE), .GATE(GATE)) gate_i (
        .occ      (occ),
        .busy     (busy),
        .in_valid (in_valid),
        .in_cls   (in_cls),
        .in_ready (in_ready),
        .acc_pipe (acc_pipe),
        .acc_long (acc_long)
    );

    fpu_ic_stages #(.NSTAGE(NSTAGE), .TAG_W(TAG_W)) stages_i (
        .clk       (clk),
        .rst       (rst),
        .push      (acc_pipe),
        .push_tag  (in_tag),
        .push_dbl  (in_dbl),
        .occ       (occ),
        .ret_valid (p_ret_v),
        .ret_tag   (p_ret_tag),
        .ret_dbl   (p_ret_dbl)
    );

    fpu_ic_long #(.LAT_W(LAT_W), .TAG_W(TAG_W), .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT)) long_i (
        .clk      (clk),
        .rst      (rst),
        .start    (acc_long),
        .lat      (in_lat),
        .tag      (in_tag),
        .dbl      (in_dbl),
        .busy     (busy),
        .done     (l_done),
        .done_tag (l_tag),
        .done_dbl (l_dbl)
    );

    always_comb begin
        out_valid = p_ret_v | l_done;
        out_tag   = '0;
        out_dbl   = 1'b0;
        if (l_done) begin
            out_tag = l_tag;
            out_dbl = l_dbl;
        end else if (p_ret_v) begin
            out_tag = p_ret_tag;
            out_dbl = p_ret_dbl;
        end
    end

    // cycles since reset release, saturating, for the latency check below
    logic [SR_W-1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                           since_rst <= '0;
        else if (since_rst != SR_W'(NSTAGE)) since_rst <= since_rst + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !out_valid); // R1

    AST_PIPE_RETIRE: assert property (@(posedge clk) disable iff (rst)
        (since_rst == SR_W'(NSTAGE)) && $past(acc_pipe, NSTAGE) |->
            out_valid && (out_tag == $past(in_tag, NSTAGE)) && (out_dbl == $past(in_dbl, NSTAGE))); // R2

    AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (rst)
        !(p_ret_v && l_done)); // R3

    AST_FRONT_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (&occ[GATE-1:0]) |-> !acc_pipe && !acc_long); // R4

    AST_LONG_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        acc_long |-> (occ == '0) && !busy); // R8

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready && !acc_pipe); // R9

    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({acc_pipe, acc_long})); // R3

endmodule

// File: tb/fpu_issue_ctl_tb_top.sv
module fpu_issue_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 8;
    localparam int LAT_W = 6;
    localparam int WD_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [TAG_W-1:0] in_tag = '0;
    logic in_dbl = 1'b0;
    logic in_cls = 1'b0;
    logic [LAT_W-1:0] in_lat = '0;
    logic out_valid;
    logic [TAG_W-1:0] out_tag;
    logic out_dbl;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpu_issue_ctl dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_dbl(in_dbl), .in_cls(in_cls), .in_lat(in_lat),
        .out_valid(out_valid), .out_tag(out_tag), .out_dbl(out_dbl)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int long_rem = 0;
    int acc_cnt = 0;
    logic [4:0] hist = '0;
    logic [7:0] tag_ctr = '0;
    logic exp_v [64];
    logic [TAG_W-1:0] exp_tag [64];
    logic exp_d [64];
    string exp_req [64];

    function automatic int clamp_ref(input int v);
        if (v < 14) return 14;
        if (v > 35) return 35;
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic step(input logic v, input logic d, input logic c, input logic [LAT_W-1:0] lat);
        int slot;
        int s;
        int lval;
        logic mrdy;
        logic acc;
        string rq;
        @(negedge clk);
        slot = cyc % 64;
        chk(exp_req[slot], int'(out_valid), int'(exp_v[slot]), "out_valid");
        if (exp_v[slot]) begin
            chk("R3", int'(out_tag), int'(exp_tag[slot]), "out_tag");
            chk("R5", int'(out_dbl), int'(exp_d[slot]), "out_dbl");
        end
        exp_v[slot] = 1'b0;
        exp_req[slot] = "R2";
        in_valid = v; in_dbl = d; in_cls = c; in_lat = lat; in_tag = tag_ctr;
        #1;
        if (long_rem > 0)  mrdy = 1'b0;
        else if (c)        mrdy = (hist == '0);
        else               mrdy = !(&hist[3:0]);
        rq = (long_rem > 0) ? "R9" : (c ? "R8" : "R4");
        chk(rq, int'(in_ready), int'(mrdy), "in_ready");
        acc = v && mrdy;
        lval = 0;
        if (acc) begin
            if (c) begin
                lval = clamp_ref(int'(lat));
                s = (cyc + lval) % 64;
                exp_req[s] = (int'(lat) < 14 || int'(lat) > 35) ? "R7" : "R6";
            end else begin
                s = (cyc + 5) % 64;
                exp_req[s] = "R2";
            end
            exp_v[s] = 1'b1;
            exp_tag[s] = tag_ctr;
            exp_d[s] = d;
            tag_ctr = tag_ctr + 1'b1;
            acc_cnt++;
        end
        @(posedge clk);
        cyc++;
        long_rem = (long_rem > 0) ? long_rem - 1 : 0;
        if (acc && c) long_rem = lval;
        hist = {hist[3:0], acc && !c};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", WD_CYCLES, WD_CYCLES);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 64; i++) begin
            exp_v[i] = 1'b0;
            exp_req[i] = "R2";
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", int'(out_valid), 0, "out_valid after reset");
        chk("R1", int'(in_ready), 1, "in_ready after reset");

        // R4: continuous offer from empty -> 16 of 20 accepted
        acc_cnt = 0;
        for (int i = 0; i < 20; i++) step(1'b1, i[0], 1'b0, '0);
        chk("R4", acc_cnt, 16, "accepts in 20 back-to-back cycles");
        idle(6);

        // R6 / R9: in-range long, with pipelined offers held during it
        step(1'b1, 1'b1, 1'b1, 6'd20);
        for (int i = 0; i < 24; i++) step(1'b1, 1'b0, 1'b0, '0);
        idle(6);

        // R7: clamp low and high
        step(1'b1, 1'b0, 1'b1, 6'd3);
        idle(16);
        step(1'b1, 1'b1, 1'b1, 6'd60);
        idle(38);
        step(1'b1, 1'b0, 1'b1, 6'd14);
        idle(16);
        step(1'b1, 1'b0, 1'b1, 6'd35);
        idle(37);

        // R8: long offered right behind a pipelined instruction
        step(1'b1, 1'b0, 1'b0, '0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b1, 6'd14);
        idle(20);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic v;
            logic c;
            v = ($urandom % 4) != 0;
            c = ($urandom % 12) == 0;
            step(v, 1'($urandom), c, 6'($urandom));
        end
        idle(40);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule